// File: doc/BRIEF.md
# FIFO Threshold Offset Programmer

This block keeps the two threshold offsets that a deep synchronous FIFO compares against its fill level to raise its almost-empty and almost-full flags. One offset counts words from the empty boundary, the other counts words from the full boundary. Both are always visible as outputs for a separate flag comparator.

Master reset is asynchronous and active low. The level of `loadN` during that reset makes two choices at once: the default value of both offsets and the only loading method that works until the next master reset. A low level picks parallel loading with a default of 127. A high level picks serial loading with a default of 1023.

In parallel mode, a write-side pointer takes a 9-bit word at each qualified write clock edge. It fills the low part, then the high part, of the empty offset, and then the same two parts of the full offset. In serial mode, one bit is taken per write clock edge into a single chain that spans both offsets. A read-side pointer returns the same four parts on the read clock in either mode. When `loadN` is high, the enable inputs belong to the FIFO memory, and this block ignores them.

Top module: `fifo_offset_prog`

## Requirements
- R1: When `loadN` is low during master reset, both offsets become 0x07F and parallel loading is selected.
- R2: When `loadN` is high during master reset, both offsets become 0x3FF and serial loading is selected. The selection holds until the next master reset.
- R3: In parallel mode, a rising `wrClk` with `loadN` and `wrEnN` both low writes `dIn` into the step given by the write pointer. Step 0 is empty offset bits [8:0]. Step 1 is empty offset bits [OFF_W-1:9], taken from `dIn[OFF_W-10:0]`. Steps 2 and 3 do the same for the full offset.
- R4: The write pointer advances by one on each parallel write and wraps from step 3 to step 0. Master reset returns it to step 0.
- R5: A rising `rdClk` with `loadN` and `rdEnN` both low loads `dOut` with the part selected by a separate read pointer, using the same step order as R3. High-part steps read as zeros above the offset's top bit. The read pointer wraps from 3 to 0 and works in both modes.
- R6: In serial mode, a rising `wrClk` with `loadN` and `serEnN` both low stores `serIn` at chain position n. Positions 0 to OFF_W-1 are empty offset bits 0 upward. The positions that follow are full offset bits 0 upward. n advances by one and wraps after 2*OFF_W bits.
- R7: The method that was not selected has no effect. In parallel mode `serEnN` is ignored. In serial mode `wrEnN` is ignored.
- R8: While `loadN` is high, the offsets, both pointers and `dOut` do not change, whatever the enables do.
- R9: Master reset discards a partly shifted serial stream. The next serial bit lands at chain position 0.
- R10: `dOut` is zero after master reset and holds its value on every read clock edge that is not a qualified read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| mrstN | input | 1 | Asynchronous master reset, active low |
| loadN | input | 1 | Offset access select, active low; also picks mode at reset |
| wrEnN | input | 1 | Write enable, active low |
| serEnN | input | 1 | Serial enable, active low |
| serIn | input | 1 | Serial data bit |
| dIn | input | DATA_W | Parallel write data |
| rdEnN | input | 1 | Read enable, active low |
| dOut | output | DATA_W | Parallel read data |
| emptyOffset | output | OFF_W | Almost-empty threshold offset |
| fullOffset | output | OFF_W | Almost-full threshold offset |

## Verification
The bench targets the points where each pointer wraps. If the write pointer did not return to step 0 after four writes, the fifth write would corrupt the full offset's high part, and if the serial counter did not wrap, bits 29 and later would be lost. It also resets in the middle of a serial stream. A design that kept its chain position across that reset would put the next bits into the wrong offset. Enables for the method that was not selected are driven in both modes, along with reads and writes while `loadN` is high, so that a leaked strobe shows up as a changed offset or a moved pointer. Reads of the high-part steps catch garbage above the offset's top bit.

// File: rtl/fop_pkg.sv
package fop_pkg;
  // Wide enough for the serial chain index of any supported offset width
  localparam int SER_IDX_W = 8;

  typedef struct packed {
    logic                 parWrite;  // parallel write of one step
    logic [1:0]           wrStep;    // step addressed by the write pointer
    logic                 serShift;  // one serial bit accepted
    logic [SER_IDX_W-1:0] serIdx;    // chain position of that bit
    logic                 rdAdv;     // parallel read of one step
    logic [1:0]           rdStep;    // step addressed by the read pointer
  } fopStrobes_t;
endpackage

// File: rtl/fop_ctrl.sv
module fop_ctrl
  import fop_pkg::*;
#(
  parameter int OFF_W = 14
) (
  input  logic        wrClk,
  input  logic        rdClk,
  input  logic        mrstN,
  input  logic        loadN,
  input  logic        wrEnN,
  input  logic        serEnN,
  input  logic        rdEnN,
  output fopStrobes_t strobes
);
  localparam int CHAIN_W = 2 * OFF_W;
  localparam logic [SER_IDX_W-1:0] LAST_IDX = SER_IDX_W'(CHAIN_W - 1);

  logic                 serialMode;
  logic [1:0]           wrPtr;
  logic [1:0]           rdPtr;
  logic [SER_IDX_W-1:0] serCnt;
  logic                 parWrite;
  logic                 serShift;
  logic                 rdAdv;

  assign parWrite = !loadN && !wrEnN && !serialMode;
  assign serShift = !loadN && !serEnN && serialMode;
  assign rdAdv    = !loadN && !rdEnN;

  // Mode is captured from loadN while master reset is held
  always_ff @(posedge wrClk or negedge mrstN) begin
    if (!mrstN) begin
      serialMode <= loadN;
      wrPtr      <= '0;
      serCnt     <= '0;
    end else begin
      if (parWrite) wrPtr <= wrPtr + 2'd1;
      if (serShift) serCnt <= (serCnt == LAST_IDX) ? '0 : serCnt + 1'b1;
    end
  end

  always_ff @(posedge rdClk or negedge mrstN) begin
    if (!mrstN) rdPtr <= '0;
    else if (rdAdv) rdPtr <= rdPtr + 2'd1;
  end

  always_comb begin
    strobes.parWrite = parWrite;
    strobes.wrStep   = wrPtr;
    strobes.serShift = serShift;
    strobes.serIdx   = serCnt;
    strobes.rdAdv    = rdAdv;
    strobes.rdStep   = rdPtr;
  end

  a_r2_mode_fixed: assert property (@(posedge wrClk) disable iff (!mrstN)
    1'b1 |=> $stable(serialMode));
  a_r4_wr_ptr_step: assert property (@(posedge wrClk) disable iff (!mrstN)
    parWrite |=> wrPtr == $past(wrPtr) + 2'd1);
  a_r4_wr_ptr_hold: assert property (@(posedge wrClk) disable iff (!mrstN)
    !parWrite |=> $stable(wrPtr));
  a_r6_ser_wrap: assert property (@(posedge wrClk) disable iff (!mrstN)
    (serShift && serCnt == LAST_IDX) |=> serCnt == '0);
  a_r6_ser_range: assert property (@(posedge wrClk) disable iff (!mrstN)
    serCnt <= LAST_IDX);
  a_r7_one_method: assert property (@(posedge wrClk) disable iff (!mrstN)
    !(parWrite && serShift));
  a_r5_rd_ptr_step: assert property (@(posedge rdClk) disable iff (!mrstN)
    rdAdv |=> rdPtr == $past(rdPtr) + 2'd1);
endmodule

// File: rtl/fop_regs.sv
module fop_regs
  import fop_pkg::*;
#(
  parameter int OFF_W   = 14,
  parameter int DATA_W  = 9,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  logic              loadN,
  input  logic              serIn,
  input  logic [DATA_W-1:0] dIn,
  input  fopStrobes_t       strobes,
  output logic [DATA_W-1:0] dOut,
  output logic [OFF_W-1:0]  emptyOffset,
  output logic [OFF_W-1:0]  fullOffset
);
  localparam int HI_W = OFF_W - DATA_W;
  localparam int NREG = 2;

  logic [OFF_W-1:0] offReg [NREG];

  // Index 0 holds the empty-side offset, index 1 the full-side offset
  for (genvar g = 0; g < NREG; g++) begin : g_off
    logic [OFF_W-1:0] nxt;

    always_comb begin
      nxt = offReg[g];
      if (strobes.parWrite && strobes.wrStep == 2'(2 * g))
        nxt[DATA_W-1:0] = dIn;
      if (strobes.parWrite && strobes.wrStep == 2'(2 * g + 1))
        nxt[OFF_W-1:DATA_W] = dIn[HI_W-1:0];
      if (strobes.serShift) begin
        for (int i = 0; i < OFF_W; i++) begin
          if (strobes.serIdx == SER_IDX_W'(g * OFF_W + i)) nxt[i] = serIn;
        end
      end
    end

    always_ff @(posedge wrClk or negedge mrstN) begin
      if (!mrstN) offReg[g] <= loadN ? OFF_W'(DEF_SER) : OFF_W'(DEF_PAR);
      else        offReg[g] <= nxt;
    end
  end

  assign emptyOffset = offReg[0];
  assign fullOffset  = offReg[1];

  logic [OFF_W-1:0]  rdReg;
  logic [DATA_W-1:0] rdWord;

  always_comb begin
    rdReg  = offReg[strobes.rdStep[1]];
    rdWord = strobes.rdStep[0] ? DATA_W'(rdReg[OFF_W-1:DATA_W]) : rdReg[DATA_W-1:0];
  end

  always_ff @(posedge rdClk or negedge mrstN) begin
    if (!mrstN)             dOut <= '0;
    else if (strobes.rdAdv) dOut <= rdWord;
  end

  a_r8_offsets_hold: assert property (@(posedge wrClk) disable iff (!mrstN)
    (!strobes.parWrite && !strobes.serShift) |=> ($stable(emptyOffset) && $stable(fullOffset)));
  a_r3_one_part: assert property (@(posedge wrClk) disable iff (!mrstN)
    strobes.parWrite |=> ($stable(emptyOffset) || $stable(fullOffset)));
  a_r10_dout_hold: assert property (@(posedge rdClk) disable iff (!mrstN)
    !strobes.rdAdv |=> $stable(dOut));
  a_r5_hi_zero: assert property (@(posedge rdClk) disable iff (!mrstN)
    (strobes.rdAdv && strobes.rdStep[0]) |=> dOut[DATA_W-1:HI_W] == '0);
endmodule

// File: rtl/fifo_offset_prog.sv
module fifo_offset_prog
  import fop_pkg::*;
#(
  parameter int OFF_W   = 14,
  parameter int DATA_W  = 9,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  logic              loadN,
  input  logic              wrEnN,
  input  logic              serEnN,
  input  logic              serIn,
  input  logic [DATA_W-1:0] dIn,
  input  logic              rdEnN,
  output logic [DATA_W-1:0] dOut,
  output logic [OFF_W-1:0]  emptyOffset,
  output logic [OFF_W-1:0]  fullOffset
);
  fopStrobes_t strobes;

  fop_ctrl #(.OFF_W(OFF_W)) i_ctrl (
    .wrClk  (wrClk),
    .rdClk  (rdClk),
    .mrstN  (mrstN),
    .loadN  (loadN),
    .wrEnN  (wrEnN),
    .serEnN (serEnN),
    .rdEnN  (rdEnN),
    .strobes(strobes)
  );

  fop_regs #(
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W),
    .DEF_PAR(DEF_PAR),
    .DEF_SER(DEF_SER)
  ) i_regs (
    .wrClk      (wrClk),
    .rdClk      (rdClk),
    .mrstN      (mrstN),
    .loadN      (loadN),
    .serIn      (serIn),
    .dIn        (dIn),
    .strobes    (strobes),
    .dOut       (dOut),
    .emptyOffset(emptyOffset),
    .fullOffset (fullOffset)
  );
endmodule

// File: tb/test_fifo_offset_prog.sv
`timescale 1ns/1ps
module test_fifo_offset_prog;
  localparam int OW = 14;
  localparam int DW = 9;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic mrstN = 1'b1, loadN = 1'b1, wrEnN = 1'b1, serEnN = 1'b1, serIn = 1'b0, rdEnN = 1'b1;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic [OW-1:0] emptyOffset, fullOffset;

  fifo_offset_prog i_fifo_offset_prog (
    .wrClk(clk), .rdClk(clk), .mrstN(mrstN), .loadN(loadN), .wrEnN(wrEnN),
    .serEnN(serEnN), .serIn(serIn), .dIn(dIn), .rdEnN(rdEnN), .dOut(dOut),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset)
  );

  int vecs = 0, errs = 0;
  logic [OW-1:0] mE, mF;
  logic [DW-1:0] mD;
  int wp, rp, sc;
  bit mSer;

  function automatic logic [DW-1:0] rdVal(int p);
    case (p)
      0:       return mE[DW-1:0];
      1:       return DW'(mE[OW-1:DW]);
      2:       return mF[DW-1:0];
      default: return DW'(mF[OW-1:DW]);
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check(tag, 32'(emptyOffset), 32'(mE), "emptyOffset");
    check(tag, 32'(fullOffset), 32'(mF), "fullOffset");
    check(tag, 32'(dOut), 32'(mD), "dOut");
  endtask

  task automatic doReset(bit ld, string tag);
    @(negedge clk);
    loadN = ld; wrEnN = 1; serEnN = 1; rdEnN = 1; mrstN = 0;
    @(posedge clk);
    @(negedge clk);
    mrstN = 1;
    mE = ld ? OW'(1023) : OW'(127); mF = mE;
    mD = '0; wp = 0; rp = 0; sc = 0; mSer = ld;
    #1 checkAll(tag);
  endtask

  task automatic cyc(bit ld, bit wEn, bit rEn, bit sEn, bit sIn, logic [DW-1:0] d, string tag);
    @(negedge clk);
    loadN = ld; wrEnN = wEn; rdEnN = rEn; serEnN = sEn; serIn = sIn; dIn = d;
    if (!ld && !rEn) begin mD = rdVal(rp); rp = (rp + 1) % 4; end
    if (!ld && !mSer && !wEn) begin
      case (wp)
        0: mE[DW-1:0] = d;
        1: mE[OW-1:DW] = d[OW-DW-1:0];
        2: mF[DW-1:0] = d;
        default: mF[OW-1:DW] = d[OW-DW-1:0];
      endcase
      wp = (wp + 1) % 4;
    end
    if (!ld && mSer && !sEn) begin
      if (sc < OW) mE[sc] = sIn; else mF[sc-OW] = sIn;
      sc = (sc + 1) % (2 * OW);
    end
    @(posedge clk);
    #1 checkAll(tag);
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1, R10: parallel defaults and cleared read data
    doReset(0, "R1");
    // R3: four distinct parts, then R5 read-back with zeroed upper bits
    cyc(0, 0, 1, 1, 0, 9'h1A5, "R3");
    cyc(0, 0, 1, 1, 0, 9'h1FF, "R3");
    cyc(0, 0, 1, 1, 0, 9'h05A, "R3");
    cyc(0, 0, 1, 1, 0, 9'h013, "R3");
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 1, 0, '0, "R5");
    // R4: fifth and sixth write wrap to the empty offset
    cyc(0, 0, 1, 1, 0, 9'h0C3, "R4");
    cyc(0, 0, 1, 1, 0, 9'h00E, "R4");
    // R7: serial enable ignored in parallel mode
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, 0, 1, '0, "R7");
    // R8: enables with loadN high touch nothing
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 1, 9'h1FF, "R8");
    // R10: no read, dOut holds
    cyc(0, 1, 1, 1, 0, 9'h123, "R10");
    // R2: serial defaults
    doReset(1, "R2");
    // R9: partial stream then reset, next bit lands at position 0
    for (int i = 0; i < 10; i++) cyc(0, 1, 1, 0, 1'(i & 1), '0, "R6");
    doReset(1, "R9");
    cyc(0, 1, 1, 0, 0, '0, "R9");
    // R6: full stream past the wrap point
    for (int i = 0; i < 2 * OW + 5; i++) cyc(0, 1, 1, 0, 1'($urandom), '0, "R6");
    // R7: parallel write ignored in serial mode; R5 reads still work
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 0, 9'h155, "R7");
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 1, 0, '0, "R5");
    // random mix in both modes
    for (int m = 0; m < 2; m++) begin
      doReset(1'(m), m == 0 ? "R1" : "R2");
      for (int i = 0; i < 3000; i++)
        cyc(($urandom % 5) == 0, 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), DW'($urandom), "R3/R5/R6/R7/R8");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule